// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Datapath

This block is the registered data path of a synchronous word-wide SRAM. It is built as a synthesizable register array. Every cycle, the block samples a command into an input register. The command is made of an address, three select inputs, a whole-word write strobe, a lane write strobe, one enable per byte lane and a write word. A write commits to the array on the following rising edge. A read loads an output register on that same following edge. The output register then drives the data bus for one cycle, unless the asynchronous output enable is high.

Loading takes two registers, the input stage and the output stage, so read data appears one clock after the address is sampled. Dropping a select or issuing a write empties the output slot after a single edge. The read path has a fixed latency and no back-pressure. The system is expected to sample `dq_out` whenever `dq_oe` is high, and nothing can stall the pipe. The array depth is a parameter. The full-size part is 128K words, and the default build is kept small.

Top module: `sram_bytewrite_pipe`

## Requirements
- R1: A command is accepted only when `en0_n` = 0, `en1` = 1 and `en2_n` = 0 at the sampling edge. Any other combination writes nothing and produces no read output.
- R2: With `all_wr_n` = 0 in an accepted command, all four bytes of the addressed word take `wdata`, whatever `lane_wr_n` and `lane_en_n` are.
- R3: With `all_wr_n` = 1 and `lane_wr_n` = 0, a lane is written only if its `lane_en_n` bit is 0, and every other lane keeps its old value. Lane bit 0 maps to data bits 7:0, bit 1 to 15:8, bit 2 to 23:16 and bit 3 to 31:24.
- R4: An accepted command with `all_wr_n` = 1 and `lane_wr_n` = 1 is a read.
- R5: For a read sampled at edge N, `dq_oe` is high and `dq_out` equals the addressed word from edge N+1 until edge N+2.
- R6: An accepted write (`all_wr_n` = 0 or `lane_wr_n` = 0) leaves `dq_oe` low in its output slot.
- R7: A cycle that is not accepted leaves `dq_oe` low in its output slot, even directly after a read, so deselection takes one edge.
- R8: `out_en_n` = 1 forces `dq_oe` low and floats `dq_out` at once, without a clock edge. Returning it to 0 restores a valid read word at once.
- R9: While `rst_n` is low and after its release, `dq_oe` stays low until a read passes through the pipe.
- R10: A read issued in the cycle right after a write to the same address returns the newly written bytes.
- R11: A lane write with all four `lane_en_n` bits at 1 changes no byte and still counts as a write for R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline flags |
| addr | input | ADDR_W | Word address, sampled every edge |
| en0_n | input | 1 | Select input, active low |
| en1 | input | 1 | Select input, active high |
| en2_n | input | 1 | Select input, active low |
| all_wr_n | input | 1 | Whole-word write strobe, active low |
| lane_wr_n | input | 1 | Lane write strobe, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*8 | Write word |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*8 | Read word, high impedance when not driven |
| dq_oe | output | 1 | High while `dq_out` carries a valid read word |

## Verification
The whole-word writes carry random lane enables and lane strobe values. This separates the R2 override from the R3 masking. The lane writes sweep single-lane, alternating and empty masks over words that were filled beforehand, so a wrong lane mapping shows up as a misplaced byte. Each of the three select inputs is dropped on its own in turn, once during writes and once between reads. The output enable is also toggled with no clock edge in the middle of a valid read slot. Back-to-back write/read pairs to one address test whether a read can reach an array word on the edge right after it was written.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;

  // Command class held in the input register after decode.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/sram_bw_cmd_reg.sv
module sram_bw_cmd_reg
  import sram_bw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              en2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [DW-1:0]     wdata,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  mask_q,
  output logic [DW-1:0]     wdata_q
);

  logic             selected;
  logic             is_write;
  logic [LANES-1:0] mask_d;
  op_e              op_d;

  always_comb begin
    selected = !en0_n && en1 && !en2_n;
    is_write = !all_wr_n || !lane_wr_n;
    if (!all_wr_n)       mask_d = '1;
    else if (!lane_wr_n) mask_d = ~lane_en_n;
    else                 mask_d = '0;
    if (!selected)       op_d = OP_IDLE;
    else if (is_write)   op_d = OP_WRITE;
    else                 op_d = OP_READ;
  end

  // Flags carry reset; the payload registers do not need it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      mask_q <= selected ? mask_d : '0;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

endmodule

// File: rtl/sram_bw_array.sv
module sram_bw_array
  import sram_bw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_word
);

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < int'(LANES); i++) begin
        if (wr_mask[i]) mem[addr][i] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  // Output register: loaded only by reads, held through writes and idles.
  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[addr];
  end

  assert_read_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_word == $past(mem[addr]));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mask[g]) |=>
        mem[$past(addr)][g] == $past(wdata[g*LANE_W +: LANE_W]));
    assert_lane_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_mask[g]) |=> mem[$past(addr)][g] == $past(mem[addr][g]));
  end

endmodule

// File: rtl/sram_bw_out_stage.sv
module sram_bw_out_stage
  import sram_bw_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_q,
  input  logic [DW-1:0] rd_word,
  input  logic          out_en_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  logic rd_vld;

  // Any non-read cycle empties the slot on the next edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= (op_q == OP_READ);
  end

  assign dq_oe  = rd_vld && !out_en_n;
  assign dq_out = dq_oe ? rd_word : 'z;

endmodule

// File: rtl/sram_bytewrite_pipe.sv
module sram_bytewrite_pipe
  import sram_bw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              en2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [DW-1:0]     wdata,
  input  logic              out_en_n,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe
);

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rd_word;

  sram_bw_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n),
    .wdata(wdata), .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q),
    .wdata_q(wdata_q)
  );

  sram_bw_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(op_q == OP_WRITE), .rd_en(op_q == OP_READ),
    .addr(addr_q), .wr_mask(mask_q), .wdata(wdata_q), .rd_word(rd_word)
  );

  sram_bw_out_stage #(.LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .rd_word(rd_word),
    .out_en_n(out_en_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assert_desel_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!en0_n && en1 && !en2_n) |=> ##1 !dq_oe);

  assert_write_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0_n && en1 && !en2_n && (!all_wr_n || !lane_wr_n)) |=> ##1 !dq_oe);

endmodule

// File: tb/tb_sram_bytewrite_pipe.sv
module tb_sram_bytewrite_pipe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        en0_n = 1'b1, en1 = 1'b0, en2_n = 1'b1;
  logic        all_wr_n = 1'b1, lane_wr_n = 1'b1;
  logic [3:0]  lane_en_n = 4'hF;
  logic [31:0] wdata = '0;
  logic        out_en_n = 1'b0;
  wire  [31:0] dq_out;
  wire         dq_oe;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  logic [31:0] model [256];

  typedef struct packed {
    logic        vld;
    logic [31:0] data;
    int          due;
    int          req;
  } exp_t;
  exp_t sb [$];

  sram_bytewrite_pipe dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en0_n(en0_n), .en1(en1),
    .en2_n(en2_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_en_n(lane_en_n), .wdata(wdata), .out_en_n(out_en_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL R%0d actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver: one command per cycle, expected slot pushed to the scoreboard.
  task automatic op(input logic [2:0] sel, input logic aw, input logic lw,
                    input logic [3:0] le, input logic [7:0] a,
                    input logic [31:0] d, input int req);
    exp_t e;
    logic acc;
    @(negedge clk);
    {en0_n, en1, en2_n} = sel;
    all_wr_n = aw; lane_wr_n = lw; lane_en_n = le; addr = a; wdata = d;
    acc = (sel == 3'b010);
    e.vld = acc && aw && lw;              // R4: both strobes high is a read
    e.data = model[a];
    e.due = cyc + 2;                      // input reg edge, output reg edge
    e.req = req;
    sb.push_back(e);
    if (acc && !aw) model[a] = d;         // R2
    else if (acc && !lw)                  // R3 lane map 0->7:0 .. 3->31:24
      for (int i = 0; i < 4; i++)
        if (!le[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic rd(input logic [7:0] a, input int req);
    op(3'b010, 1'b1, 1'b1, 4'hF, a, 32'h0, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(3'b110, 1'b1, 1'b1, 4'hF, 8'h0, 32'h0, 7);
  endtask

  // Monitor: compares each slot in the cycle it is due.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() != 0 && sb[0].due <= cyc) begin
        exp_t e;
        logic want;
        e = sb.pop_front();
        want = e.vld && !out_en_n;
        check(dq_oe == want, e.req, {31'b0, dq_oe}, {31'b0, want});
        if (want) check(dq_out == e.data, e.req, dq_out, e.data);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    misses++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(dq_oe == 1'b0, 9, {31'b0, dq_oe}, 32'h0);   // R9 in reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dq_oe == 1'b0, 9, {31'b0, dq_oe}, 32'h0);   // R9 after release

    // R2/R6: whole-word writes with lane enables and strobe scrambled.
    for (int i = 0; i < 8; i++)
      op(3'b010, 1'b0, 1'(i % 2), 4'(i * 5), 8'(i), 32'hA5000000 + 32'(i * 32'h01010101), 2);
    for (int i = 0; i < 8; i++) rd(8'(i), 2);

    // R3: lane writes over filled words, varied masks.
    op(3'b010, 1'b1, 1'b0, 4'b1110, 8'd0, 32'h11223344, 3);
    op(3'b010, 1'b1, 1'b0, 4'b0111, 8'd1, 32'h55667788, 3);
    op(3'b010, 1'b1, 1'b0, 4'b1010, 8'd2, 32'h99AABBCC, 3);
    op(3'b010, 1'b1, 1'b0, 4'b0101, 8'd3, 32'hDDEEFF00, 3);
    op(3'b010, 1'b1, 1'b0, 4'b1101, 8'd4, 32'h0BADF00D, 3);
    // R11: empty lane mask writes nothing.
    op(3'b010, 1'b1, 1'b0, 4'b1111, 8'd5, 32'hFFFFFFFF, 11);
    for (int i = 0; i < 6; i++) rd(8'(i), 3);

    // R1: each select dropped alone during writes, then reads show no change.
    op(3'b110, 1'b0, 1'b1, 4'h0, 8'd6, 32'hDEAD0001, 1);
    op(3'b000, 1'b0, 1'b1, 4'h0, 8'd6, 32'hDEAD0002, 1);
    op(3'b011, 1'b0, 1'b1, 4'h0, 8'd6, 32'hDEAD0003, 1);
    rd(8'd6, 1);
    op(3'b000, 1'b1, 1'b1, 4'hF, 8'd7, 32'h0, 1);      // R1 read not accepted

    // R7: deselect between reads, one select at a time.
    rd(8'd0, 7); op(3'b110, 1'b1, 1'b1, 4'hF, 8'd0, 32'h0, 7);
    rd(8'd1, 7); op(3'b000, 1'b1, 1'b1, 4'hF, 8'd1, 32'h0, 7);
    rd(8'd2, 7); op(3'b011, 1'b1, 1'b1, 4'hF, 8'd2, 32'h0, 7); rd(8'd3, 7);

    // R10: write then read same word on the next cycle.
    for (int i = 0; i < 4; i++) begin
      op(3'b010, 1'b0, 1'b1, 4'hF, 8'(32 + i), 32'hC0DE0000 | 32'(i), 10);
      rd(8'(32 + i), 10);
    end
    op(3'b010, 1'b1, 1'b0, 4'b0110, 8'd32, 32'h12345678, 10);
    rd(8'd32, 10);
    idle(4);

    // R8: asynchronous output enable inside a valid slot.
    @(negedge clk);
    {en0_n, en1, en2_n} = 3'b010; all_wr_n = 1'b1; lane_wr_n = 1'b1; addr = 8'd33;
    @(negedge clk);
    {en0_n, en1, en2_n} = 3'b110;
    @(posedge clk); #5;
    check(dq_oe == 1'b1, 8, {31'b0, dq_oe}, 32'h1);
    check(dq_out == model[33], 8, dq_out, model[33]);
    out_en_n = 1'b1; #1;
    check(dq_oe == 1'b0, 8, {31'b0, dq_oe}, 32'h0);
    out_en_n = 1'b0; #1;
    check(dq_oe == 1'b1, 8, {31'b0, dq_oe}, 32'h1);
    check(dq_out == model[33], 8, dq_out, model[33]);
    // R8 through the scoreboard: output enable held high over read slots.
    @(negedge clk); out_en_n = 1'b1;
    rd(8'd0, 8); rd(8'd1, 8);
    idle(2);
    @(negedge clk); out_en_n = 1'b0;
    rd(8'd1, 5);
    idle(4);
    finish_run();
  end

endmodule